// File: doc/BRIEF.md
# Configuration Completion Receiver

This block waits for the completion that answers one outstanding configuration request and turns it into a single result. A request is registered with its kind (read or write), its access size and the low bits of its register offset. The completion then arrives as a stream of beats. Each beat carries two 32-bit words and a start and end flag. The block takes the completion status from the start beat and the data from the end beat. It then raises a one-cycle done pulse with a result code and, for reads, the requested byte, halfword or full word of the returned data.

A completion that never ends is handled by a bounded wait. The block counts clock cycles only while a request is pending. When the limit runs out, it ends the request with a device-not-found result. Only one request can be outstanding at a time. A completion is expected to carry at most one data word.

Top module: `cfg_cpl_rx`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `rd_data` is 0. Outside the done pulse, `result` and `rd_data` read as 0.
- R2: While a request is pending and no packet is open, a valid beat that has neither the start flag nor the end flag is ignored. It causes no done pulse and does not change the result of the completion that follows.
- R3: The start beat's second word holds the completion status in bits 14:12. When the end beat arrives, a non-zero status gives `result` = 1 (device not found) and `rd_data` = 0.
- R4: When the latched status is zero, the end beat gives `result` = 0 (success), and the read data is taken from the first word of the end beat. A beat with both flags set is a complete packet, and its own status field applies.
- R5: Byte read (`req_size` = 0): `rd_data` = (word >> 8*`req_offset`[1:0]) & 0xFF.
- R6: Halfword read (`req_size` = 1): `rd_data` = (word >> 8*(`req_offset` & 2)) & 0xFFFF.
- R7: Word read (`req_size` = 2 or 3): `rd_data` is the word unchanged.
- R8: Suppose no end beat is accepted within TIMEOUT_CYCLES clock edges after the edge that registers the request. Then `done` rises after exactly that many edges, with `result` = 1 and `rd_data` = 0.
- R9: A write request (`req_is_read` = 0) also waits for its completion and reports its status through `result`. It always returns `rd_data` = 0.
- R10: A start beat that arrives while a packet is already open restarts the capture. The status of the newest start beat is the one that decides the result.
- R11: `done` is a single-cycle pulse. It is visible in the cycle after the edge that accepts the end beat. A `req_valid` that arrives while a request is pending is ignored.
- R12: While no request is pending, beats are ignored and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Registers a new pending request when idle |
| req_is_read | input | 1 | 1 = read request, 0 = write request |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_offset | input | 2 | Low two bits of the register offset |
| beat_valid | input | 1 | Beat present this cycle |
| beat_sop | input | 1 | Start-of-packet flag |
| beat_eop | input | 1 | End-of-packet flag |
| beat_w0 | input | 32 | First word of the beat |
| beat_w1 | input | 32 | Second word of the beat |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | 0 success, 1 device not found |
| rd_data | output | 32 | Extracted read data |

## Verification
The bench goes after several corner cases, each of which a faulty design would show at the ports:
- A single beat with both flags set. A design that read the status from a stale latch would report the wrong result.
- A second start beat. If the design kept the first status, a good completion would be reported as not found.
- Unflagged beats before the start beat. A design that captured them would finish early.
- Status bits placed in the end beat only. A design that decoded status there would flip the result.
- A missing completion. Its done pulse must arrive on exactly the TIMEOUT_CYCLES-th edge, even with a second request driven mid-wait. A counter that restarts or is off by one fails this.
- The offset and size lane selection and write handling, which are randomized against a bench-side model.

// File: rtl/cfg_cpl_pkg.sv
package cfg_cpl_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_WORD3 = 2'd3
    } acc_size_e;

    typedef enum logic {
        RES_SUCCESS  = 1'b0,
        RES_NO_DEVICE = 1'b1
    } cpl_result_e;

    localparam int CPL_ST_LSB = 12;
    localparam int CPL_ST_W   = 3;

    typedef struct packed {
        logic      is_read;
        acc_size_e size;
        logic [1:0] offset;
    } req_info_t;

    function automatic logic [31:0] pick_lanes(input acc_size_e sz,
                                               input logic [1:0] off,
                                               input logic [31:0] word);
        logic [31:0] shifted;
        case (sz)
            ACC_BYTE: begin
                shifted = word >> {off, 3'b000};
                return {24'd0, shifted[7:0]};
            end
            ACC_HALF: begin
                shifted = word >> {off[1], 4'b0000};
                return {16'd0, shifted[15:0]};
            end
            default: return word;
        endcase
    endfunction

endpackage

// File: rtl/cpl_pkt_tracker.sv
module cpl_pkt_tracker
    import cfg_cpl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                enable,
    input  logic                sop,
    input  logic                eop,
    input  logic [31:0]         w1,
    output logic                take_end,
    output logic [CPL_ST_W-1:0] status_now
);
    logic                open_q;
    logic [CPL_ST_W-1:0] st_q;
    logic                accept;
    logic [CPL_ST_W-1:0] st_field;

    assign st_field   = w1[CPL_ST_LSB +: CPL_ST_W];
    assign accept     = enable && (sop || eop || open_q);
    assign take_end   = accept && eop;
    // a start beat in the same cycle supersedes any earlier status
    assign status_now = (accept && sop) ? st_field : st_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            open_q <= 1'b0;
            st_q   <= '0;
        end else if (accept && sop) begin
            open_q <= 1'b1;
            st_q   <= st_field;
        end
    end
endmodule

// File: rtl/cpl_wait_timer.sv
module cpl_wait_timer #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(TIMEOUT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cpl_lane_extract.sv
module cpl_lane_extract
    import cfg_cpl_pkg::*;
(
    input  req_info_t   info,
    input  logic [31:0] word,
    output logic [31:0] data
);
    always_comb begin
        data = info.is_read ? pick_lanes(info.size, info.offset, word) : 32'd0;
    end
endmodule

// File: rtl/cfg_cpl_rx.sv
module cfg_cpl_rx
    import cfg_cpl_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_is_read,
    input  logic [1:0]  req_size,
    input  logic [1:0]  req_offset,
    input  logic        beat_valid,
    input  logic        beat_sop,
    input  logic        beat_eop,
    input  logic [31:0] beat_w0,
    input  logic [31:0] beat_w1,
    output logic        done,
    output logic        result,
    output logic [31:0] rd_data
);
    logic                pending;
    req_info_t           info_q;
    logic                take_end;
    logic [CPL_ST_W-1:0] status_now;
    logic                expired;
    logic [31:0]         lane_data;

    cpl_pkt_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .clear      (!pending || done),
        .enable     (pending && beat_valid),
        .sop        (beat_sop),
        .eop        (beat_eop),
        .w1         (beat_w1),
        .take_end   (take_end),
        .status_now (status_now)
    );

    cpl_wait_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (pending),
        .expired (expired)
    );

    cpl_lane_extract u_lane (
        .info (info_q),
        .word (beat_w0),
        .data (lane_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            info_q  <= '0;
            done    <= 1'b0;
            result  <= RES_SUCCESS;
            rd_data <= '0;
        end else begin
            done    <= 1'b0;
            result  <= RES_SUCCESS;
            rd_data <= '0;
            if (!pending) begin
                if (req_valid) begin
                    pending        <= 1'b1;
                    info_q.is_read <= req_is_read;
                    info_q.size    <= acc_size_e'(req_size);
                    info_q.offset  <= req_offset;
                end
            end else if (take_end) begin
                pending <= 1'b0;
                done    <= 1'b1;
                if (status_now != '0) begin
                    result <= RES_NO_DEVICE;
                end else begin
                    rd_data <= lane_data;
                end
                info_q <= '0;
            end else if (expired) begin
                pending <= 1'b0;
                done    <= 1'b1;
                result  <= RES_NO_DEVICE;
                info_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/cfg_cpl_rx_chk.sv
module cfg_cpl_rx_chk #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        pending,
    input logic        is_read,
    input logic        done,
    input logic        result,
    input logic [31:0] rd_data
);
    localparam int PW = $clog2(TIMEOUT_CYCLES + 2);
    logic [PW-1:0] pend_run;

    always_ff @(posedge clk) begin
        if (rst || !pending) pend_run <= '0;
        else pend_run <= pend_run + 1'b1;
    end

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: the wait never exceeds its limit
    a_r8_bounded_wait: assert property (@(posedge clk) disable iff (rst)
        pend_run <= PW'(TIMEOUT_CYCLES));

    // R12: no done without a pending request before it
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(pending) |-> !done);

    // R11: done only when the request has just closed
    a_r11_done_closes: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pending && $past(pending)));

    // R1: outputs quiet outside the pulse
    a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
        !done |-> (rd_data == 32'd0 && !result));

    // R3: a not-found result carries no data
    a_r3_nf_no_data: assert property (@(posedge clk) disable iff (rst)
        (done && result) |-> rd_data == 32'd0);

    // R9: a write returns no data
    a_r9_write_no_data: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(is_read)) |-> rd_data == 32'd0);
endmodule

bind cfg_cpl_rx cfg_cpl_rx_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pending (pending),
    .is_read (info_q.is_read),
    .done    (done),
    .result  (result),
    .rd_data (rd_data)
);

// File: tb/tb_cfg_cpl_rx.sv
module tb_cfg_cpl_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_read;
    logic [1:0]  req_size, req_offset;
    logic        beat_valid, beat_sop, beat_eop;
    logic [31:0] beat_w0, beat_w1;
    logic        done, result;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    cfg_cpl_rx #(.TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_is_read(req_is_read),
        .req_size(req_size), .req_offset(req_offset),
        .beat_valid(beat_valid), .beat_sop(beat_sop), .beat_eop(beat_eop),
        .beat_w0(beat_w0), .beat_w1(beat_w1),
        .done(done), .result(result), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_data(input bit rd, input logic [1:0] sz,
                                               input logic [1:0] off, input logic [31:0] w);
        logic [7:0] b [4];
        if (!rd) return 32'd0;
        for (int i = 0; i < 4; i++) b[i] = w[8*i +: 8];
        if (sz == 2'd0) return {24'd0, b[off]};
        if (sz == 2'd1) return off[1] ? {16'd0, b[3], b[2]} : {16'd0, b[1], b[0]};
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_beat();
        beat_valid = 0; beat_sop = 0; beat_eop = 0; beat_w0 = '0; beat_w1 = '0;
    endtask

    task automatic put_beat(input bit s, input bit e, input logic [31:0] w0, input logic [31:0] w1);
        beat_valid = 1; beat_sop = s; beat_eop = e; beat_w0 = w0; beat_w1 = w1;
    endtask

    // at a negedge: issue request; returns at the next negedge with req cleared
    task automatic issue(input bit rd, input logic [1:0] sz, input logic [1:0] off);
        req_valid = 1; req_is_read = rd; req_size = sz; req_offset = off;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_check(input string tag, input bit exp_nf, input logic [31:0] exp_d);
        @(negedge clk);
        idle_beat();
        check({tag, " done"}, {31'd0, done}, 32'd1);
        check({tag, " result"}, {31'd0, result}, {31'd0, exp_nf});
        check({tag, " data"}, rd_data, exp_d);
        @(negedge clk);
        check("R11 pulse ends", {31'd0, done}, 32'd0);
    endtask

    task automatic rand_txn();
        bit rd = 1'($urandom);
        logic [1:0] sz = 2'($urandom);
        logic [1:0] off = 2'($urandom);
        logic [2:0] st = ($urandom % 3 == 0) ? 3'($urandom | 1) : 3'd0;
        logic [31:0] d = $urandom;
        logic [31:0] junk = $urandom & ~32'h7000;
        int mids = $urandom % 3;
        bit one = ($urandom % 4 == 0);
        issue(rd, sz, off);
        if (one) begin
            put_beat(1, 1, d, junk | (32'(st) << 12));
        end else begin
            put_beat(1, 0, $urandom, junk | (32'(st) << 12));
            for (int k = 0; k < mids; k++) begin
                @(negedge clk);
                if ($urandom % 2 == 0) idle_beat();
                else put_beat(0, 0, $urandom, $urandom);
            end
            @(negedge clk);
            put_beat(0, 1, d, $urandom);
        end
        finish_check(rd ? (sz == 0 ? "R5/R3" : sz == 1 ? "R6/R3" : "R7/R3") : "R9/R3",
                     st != 0, (st == 0) ? model_data(rd, sz, off, d) : 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; req_valid = 0; req_is_read = 0; req_size = 0; req_offset = 0;
        idle_beat();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 result", {31'd0, result}, 32'd0);
        check("R1 data", rd_data, 32'd0);

        // R12: beats while idle are ignored
        put_beat(1, 1, 32'hDEAD_BEEF, 32'h0);
        @(negedge clk);
        idle_beat();
        @(negedge clk);
        check("R12 idle beat", {31'd0, done}, 32'd0);

        // R4: single both-flag beat, status zero, word read
        issue(1, 2'd2, 2'd0);
        put_beat(1, 1, 32'hA1B2_C3D4, 32'h0000_0FFF);
        finish_check("R4 single", 0, 32'hA1B2_C3D4);

        // R2: unflagged beats before start are ignored
        issue(1, 2'd0, 2'd3);
        put_beat(0, 0, 32'h1111_1111, 32'h0000_7000);
        @(negedge clk);
        check("R2 no early done", {31'd0, done}, 32'd0);
        put_beat(1, 0, 32'h0, 32'h0);
        @(negedge clk);
        put_beat(0, 1, 32'h5566_7788, 32'h0000_7000);
        finish_check("R2/R5 byte3", 0, 32'h0000_0055);

        // R10: second start beat restarts with its own status
        issue(1, 2'd1, 2'd2);
        put_beat(1, 0, 32'h0, 32'h0000_2000);
        @(negedge clk);
        put_beat(1, 0, 32'h0, 32'h0000_0000);
        @(negedge clk);
        put_beat(0, 1, 32'hCAFE_0123, 32'h0);
        finish_check("R10/R6 restart ok", 0, 32'h0000_CAFE);

        issue(1, 2'd2, 2'd0);
        put_beat(1, 0, 32'h0, 32'h0);
        @(negedge clk);
        put_beat(1, 0, 32'h0, 32'h0000_4000);
        @(negedge clk);
        put_beat(0, 1, 32'h1234_5678, 32'h0);
        finish_check("R10/R3 restart bad", 1, 32'h0);

        // R9: write with bad status
        issue(0, 2'd2, 2'd0);
        put_beat(1, 1, 32'hFFFF_FFFF, 32'h0000_1000);
        finish_check("R9 write fail", 1, 32'h0);

        // R8/R11: timeout, with a second request ignored mid-wait
        issue(1, 2'd2, 2'd0);
        for (int i = 0; i < TMO - 1; i++) begin
            if (i == 4) req_valid = 1;
            if (i == 5) req_valid = 0;
            @(negedge clk);
        end
        req_valid = 0;
        check("R8 no early timeout", {31'd0, done}, 32'd0);
        finish_check("R8 timeout", 1, 32'h0);

        for (int t = 0; t < 40; t++) rand_txn();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule